// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block behaves like a small serial EEPROM on a three-wire bus: a select line, a serial clock and a data input. Data comes back on a data output that has its own enable, so it can be tri-stated. Internally the serial pins are brought into a system clock domain through a short synchronizer. Rising edges of the serial clock are found by comparing successive samples. Every function is decoded from those samples.

A host selects the device and clocks in a frame. The frame is a start bit, then a two-bit opcode, then an address, then data for the write-type commands. The block holds a register array, and a strap input picks how that array is seen: as 16-bit words or as 8-bit bytes. Reads stream words out for as long as the select line stays high. The erase and write commands wait for select to drop, and then run a self-timed programming cycle. Its length is a parameter, counted in system clocks. While that cycle runs, the data output answers a status poll. A write-enable latch, cleared by reset, stops any command that would modify the array.

Top module: `serial3_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear, `sdout_en` is low, and every word of the array holds all ones.
- R2: A frame begins only at a serial clock rising edge where select and data-in are both high, so low data bits clocked before it are ignored. The two bits after the start bit are the opcode, first bit first: 10 read, 01 write, 11 erase. With opcode 00, the top two address bits pick the command: 11 enables writes, 00 disables writes, 10 erases all, 01 writes all.
- R3: The address is sent most significant bit first. It is ADDR_W bits long in word mode (`wide_mode` high) and ADDR_W+1 bits long in byte mode. In byte mode, address bit 0 picks the half of word address[ADDR_W:1]: 0 selects bits 7:0 and 1 selects bits 15:8.
- R4: A read drives one 0 bit on `sdout` with `sdout_en` high, from the rising edge that samples the last address bit. Each following rising edge then presents the next data bit, most significant first: 16 bits in word mode, 8 bits in byte mode.
- R5: While select stays high after a word, the address steps up by one and the next word follows with no dummy bit. The address wraps from the last location to 0.
- R6: A write, after its data bits, programs the addressed word or byte when select falls.
- R7: An erase sets every bit of the addressed word, or of the addressed byte in byte mode, to 1 when select falls.
- R8: Erase-all sets every word to all ones. Write-all stores the data in every word; in byte mode the data byte fills both halves of every word.
- R9: While the write-enable latch is clear, erase, write, erase-all and write-all change nothing and start no programming cycle. Reads work whatever the latch state.
- R10: After select falls to begin programming, a poll with select high shows `sdout` 0 for busy for about PROG_CYCLES system clocks, then 1 for ready.
- R11: A frame clocked in while programming is in progress is ignored.
- R12: A frame cut short by select falling before its last bit has no effect.
- R13: `sdout_en` is low whenever select is low.
- R14: Once a command has all its bits, further serial clocks and data bits are ignored until select goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| csel | input | 1 | Device select, active high |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in |
| wide_mode | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes |
| sdout | output | 1 | Serial data out / ready-busy status |
| sdout_en | output | 1 | Output enable for sdout |

## Verification
The bench fills every word of a 16-word array with its own pattern. It then reads the whole array back in one streamed read that runs past the last word. A design that fails to wrap, that skips the dummy bit, or that inserts a dummy bit between words returns words shifted by one bit. Byte mode is checked through both halves of one word, with the result then read back in word mode, so a swapped half-select shows up as a wrong word. The bench also targets frames the design must ignore: a write or erase sent with the latch clear, a frame cut short, extra bits clocked in after a finished command, and a frame sent during a programming cycle. A design that acts on any of these changes a stored word or raises a busy poll where none should be.

// File: rtl/s3e_pkg.sv
package s3e_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADDR,
      ST_DATA,
      ST_READ,
      ST_ARMED,
      ST_HOLD
   } frame_st_e;

   typedef enum logic [1:0] {
      PG_ERASE,
      PG_WRITE,
      PG_ERAL,
      PG_WRAL
   } prog_e;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_ERASE = 2'b11;

   localparam logic [1:0] EXT_WEN_ON  = 2'b11;
   localparam logic [1:0] EXT_WEN_OFF = 2'b00;
   localparam logic [1:0] EXT_ERS_ALL = 2'b10;

endpackage

// File: rtl/s3e_pin_sync.sv
module s3e_pin_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("s3e_pin_sync: WIDTH must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("s3e_pin_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [WIDTH-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q <= '0;
         else        stage_q <= d;
      end
      assign q = stage_q;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
   end

endmodule

// File: rtl/s3e_prog_timer.sv
module s3e_prog_timer #(
   parameter int CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("s3e_prog_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (start)          left_q <= CW'(CYCLES);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign busy = (left_q != '0);

endmodule

// File: rtl/s3e_store.sv
module s3e_store
   import s3e_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_mode,
   input  logic              prog_go,
   input  prog_e             prog_kind,
   input  logic [ADDR_W:0]   addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_word
);

   localparam int WORDS = 1 << ADDR_W;
   localparam int HALF  = DATA_W / 2;

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_data
      $error("s3e_store: DATA_W must be even and at least 4");
   end

   logic [DATA_W-1:0] mem [WORDS];
   logic [ADDR_W-1:0] word_idx;
   logic              upper;
   logic [HALF-1:0]   wbyte;
   logic [DATA_W-1:0] sel_word;

   assign word_idx = byte_mode ? addr[ADDR_W:1] : addr[ADDR_W-1:0];
   assign upper    = addr[0];
   assign wbyte    = wdata[HALF-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '1;
      end else if (prog_go) begin
         for (int w = 0; w < WORDS; w++) begin
            case (prog_kind)
               PG_ERAL: mem[w] <= '1;
               PG_WRAL: mem[w] <= byte_mode ? {wbyte, wbyte} : wdata;
               PG_ERASE: begin
                  if (word_idx == ADDR_W'(w)) begin
                     if (!byte_mode)  mem[w] <= '1;
                     else if (upper)  mem[w][DATA_W-1:HALF] <= '1;
                     else             mem[w][HALF-1:0] <= '1;
                  end
               end
               default: begin
                  if (word_idx == ADDR_W'(w)) begin
                     if (!byte_mode)  mem[w] <= wdata;
                     else if (upper)  mem[w][DATA_W-1:HALF] <= wbyte;
                     else             mem[w][HALF-1:0] <= wbyte;
                  end
               end
            endcase
         end
      end
   end

   assign sel_word = mem[word_idx];

   always_comb begin
      if (!byte_mode)  rd_word = sel_word;
      else if (upper)  rd_word = {sel_word[DATA_W-1:HALF], {HALF{1'b0}}};
      else             rd_word = {sel_word[HALF-1:0], {HALF{1'b0}}};
   end

endmodule

// File: rtl/s3e_frame.sv
module s3e_frame
   import s3e_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sck_s,
   input  logic              di_s,
   input  logic              byte_mode,
   input  logic              busy,
   input  logic [DATA_W-1:0] rd_word,
   output logic [ADDR_W:0]   addr,
   output logic [DATA_W-1:0] wdata,
   output logic              prog_go,
   output prog_e             prog_kind,
   output logic              wen,
   output logic              idle,
   output logic              sdout,
   output logic              sdout_en
);

   localparam int AMAX    = ADDR_W + 1;
   localparam int LONGEST = (AMAX > DATA_W) ? AMAX : DATA_W;
   localparam int CNT_W   = $clog2(LONGEST + 1);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("s3e_frame: ADDR_W must be at least 2");
   end

   frame_st_e         st;
   logic              sck_q;
   logic [1:0]        opc;
   logic [CNT_W-1:0]  cnt;
   logic              poll;
   logic [DATA_W-1:0] shreg;
   logic              sck_rise;
   logic [CNT_W-1:0]  aw_last;
   logic [CNT_W-1:0]  dw_last;
   logic [AMAX-1:0]   addr_nx;
   logic [AMAX-1:0]   addr_inc;
   logic [1:0]        ext_code;

   assign sck_rise = sck_s & ~sck_q;
   assign aw_last  = byte_mode ? CNT_W'(AMAX - 1)       : CNT_W'(ADDR_W - 1);
   assign dw_last  = byte_mode ? CNT_W'(DATA_W / 2 - 1) : CNT_W'(DATA_W - 1);
   assign idle     = (st == ST_IDLE);

   always_comb begin
      addr_nx  = {addr[AMAX-2:0], di_s};
      ext_code = byte_mode ? addr_nx[AMAX-1 -: 2] : addr_nx[ADDR_W-1 -: 2];
      addr_inc = addr + 1'b1;
      if (!byte_mode) addr_inc[AMAX-1] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         sck_q     <= 1'b0;
         opc       <= 2'b00;
         cnt       <= '0;
         poll      <= 1'b0;
         shreg     <= '0;
         addr      <= '0;
         wdata     <= '0;
         prog_go   <= 1'b0;
         prog_kind <= PG_ERASE;
         wen       <= 1'b0;
         sdout     <= 1'b0;
         sdout_en  <= 1'b0;
      end else begin
         sck_q   <= sck_s;
         prog_go <= 1'b0;
         if (!cs_s) begin
            if (st == ST_ARMED) begin
               prog_go <= 1'b1;
               poll    <= 1'b1;
            end
            st       <= ST_IDLE;
            sdout_en <= 1'b0;
         end else begin
            if (st == ST_IDLE) begin
               sdout_en <= poll;
               sdout    <= ~busy;
            end
            if (sck_rise) begin
               case (st)
                  ST_IDLE: begin
                     if (di_s && !busy) begin
                        st       <= ST_OPC;
                        poll     <= 1'b0;
                        cnt      <= '0;
                        addr     <= '0;
                        wdata    <= '0;
                        sdout_en <= 1'b0;
                     end
                  end
                  ST_OPC: begin
                     opc <= {opc[0], di_s};
                     if (cnt == CNT_W'(1)) begin
                        st  <= ST_ADDR;
                        cnt <= '0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  ST_ADDR: begin
                     addr <= addr_nx;
                     if (cnt == aw_last) begin
                        cnt <= '0;
                        case (opc)
                           OPC_READ: begin
                              st       <= ST_READ;
                              sdout    <= 1'b0;
                              sdout_en <= 1'b1;
                           end
                           OPC_WRITE: begin
                              st        <= ST_DATA;
                              prog_kind <= PG_WRITE;
                           end
                           OPC_ERASE: begin
                              prog_kind <= PG_ERASE;
                              st        <= wen ? ST_ARMED : ST_HOLD;
                           end
                           default: begin
                              case (ext_code)
                                 EXT_WEN_ON: begin
                                    wen <= 1'b1;
                                    st  <= ST_HOLD;
                                 end
                                 EXT_WEN_OFF: begin
                                    wen <= 1'b0;
                                    st  <= ST_HOLD;
                                 end
                                 EXT_ERS_ALL: begin
                                    prog_kind <= PG_ERAL;
                                    st        <= wen ? ST_ARMED : ST_HOLD;
                                 end
                                 default: begin
                                    prog_kind <= PG_WRAL;
                                    st        <= ST_DATA;
                                 end
                              endcase
                           end
                        endcase
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  ST_DATA: begin
                     wdata <= {wdata[DATA_W-2:0], di_s};
                     if (cnt == dw_last) st <= wen ? ST_ARMED : ST_HOLD;
                     else                cnt <= cnt + 1'b1;
                  end
                  ST_READ: begin
                     if (cnt == '0) begin
                        sdout <= rd_word[DATA_W-1];
                        shreg <= {rd_word[DATA_W-2:0], 1'b0};
                        cnt   <= dw_last;
                     end else begin
                        sdout <= shreg[DATA_W-1];
                        shreg <= {shreg[DATA_W-2:0], 1'b0};
                        cnt   <= cnt - 1'b1;
                        if (cnt == CNT_W'(1)) addr <= addr_inc;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/serial3_eeprom.sv
module serial3_eeprom
   import s3e_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 16,
   parameter int PROG_CYCLES = 20000,
   parameter int SYNC_STAGES = 2
) (
   input  logic sys_clk,
   input  logic rst_n,
   input  logic csel,
   input  logic sclk,
   input  logic sdin,
   input  logic wide_mode,
   output logic sdout,
   output logic sdout_en
);

   logic              cs_s;
   logic              sck_s;
   logic              di_s;
   logic              busy;
   logic              prog_go;
   prog_e             prog_kind;
   logic [ADDR_W:0]   addr;
   logic [DATA_W-1:0] wdata;
   logic [DATA_W-1:0] rd_word;
   logic              wen_latch;
   logic              frame_idle;

   s3e_pin_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (sys_clk),
      .rst_n (rst_n),
      .d     ({csel, sclk, sdin}),
      .q     ({cs_s, sck_s, di_s})
   );

   s3e_frame #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_frame (
      .clk       (sys_clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .sck_s     (sck_s),
      .di_s      (di_s),
      .byte_mode (~wide_mode),
      .busy      (busy),
      .rd_word   (rd_word),
      .addr      (addr),
      .wdata     (wdata),
      .prog_go   (prog_go),
      .prog_kind (prog_kind),
      .wen       (wen_latch),
      .idle      (frame_idle),
      .sdout     (sdout),
      .sdout_en  (sdout_en)
   );

   s3e_store #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_store (
      .clk       (sys_clk),
      .rst_n     (rst_n),
      .byte_mode (~wide_mode),
      .prog_go   (prog_go),
      .prog_kind (prog_kind),
      .addr      (addr),
      .wdata     (wdata),
      .rd_word   (rd_word)
   );

   s3e_prog_timer #(
      .CYCLES (PROG_CYCLES)
   ) u_timer (
      .clk   (sys_clk),
      .rst_n (rst_n),
      .start (prog_go),
      .busy  (busy)
   );

endmodule

// File: rtl/s3e_chk.sv
module s3e_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_s,
   input logic busy,
   input logic idle,
   input logic prog_go,
   input logic wen,
   input logic sdout,
   input logic sdout_en
);

   p_hiz_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !sdout_en);

   p_latch_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |-> wen);

   p_prog_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |=> busy);

   p_busy_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sdout_en && busy && idle) |-> !sdout);

   p_no_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idle && cs_s) |=> idle);

   p_no_prog_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !prog_go);

endmodule

bind serial3_eeprom s3e_chk u_chk (
   .clk      (sys_clk),
   .rst_n    (rst_n),
   .cs_s     (cs_s),
   .busy     (busy),
   .idle     (frame_idle),
   .prog_go  (prog_go),
   .wen      (wen_latch),
   .sdout    (sdout),
   .sdout_en (sdout_en)
);

// File: tb/sim_serial3_eeprom.sv
`timescale 1ns/1ps
module sim_serial3_eeprom;

   localparam int AW = 4;
   localparam int NW = 1 << AW;
   localparam int PC = 300;

   logic sys_clk   = 1'b0;
   logic rst_n     = 1'b0;
   logic csel      = 1'b0;
   logic sclk      = 1'b0;
   logic sdin      = 1'b0;
   logic wide_mode = 1'b1;
   logic sdout;
   logic sdout_en;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;
   logic [15:0] model [NW];

   always #2.5 sys_clk = ~sys_clk;

   serial3_eeprom #(
      .ADDR_W      (AW),
      .DATA_W      (16),
      .PROG_CYCLES (PC),
      .SYNC_STAGES (2)
   ) u0 (
      .sys_clk   (sys_clk),
      .rst_n     (rst_n),
      .csel      (csel),
      .sclk      (sclk),
      .sdin      (sdin),
      .wide_mode (wide_mode),
      .sdout     (sdout),
      .sdout_en  (sdout_en)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge sys_clk);
   endtask

   task automatic sbit(input logic b, output logic r, output logic en);
      sdin = b;
      waitc(3);
      sclk = 1'b1;
      waitc(6);
      r    = sdout;
      en   = sdout_en;
      sclk = 1'b0;
      waitc(3);
   endtask

   task automatic shift_out(input logic [31:0] v, input int n);
      logic r, e;
      for (int i = n - 1; i >= 0; i--) sbit(v[i], r, e);
   endtask

   function automatic int awid();
      return wide_mode ? AW : AW + 1;
   endfunction

   task automatic begin_cmd(input logic [1:0] op, input int lead = 0);
      logic r, e;
      csel = 1'b1;
      waitc(4);
      for (int i = 0; i < lead; i++) sbit(1'b0, r, e);
      sbit(1'b1, r, e);
      shift_out({30'd0, op}, 2);
   endtask

   task automatic end_cmd();
      csel = 1'b0;
      waitc(10);
   endtask

   task automatic ext_cmd(input logic [1:0] code);
      begin_cmd(2'b00);
      shift_out(32'(code) << (awid() - 2), awid());
   endtask

   task automatic expect_prog(input string tag);
      int elapsed;
      csel = 1'b0;
      waitc(8);
      check("R13 released while select low", {31'd0, sdout_en}, 32'd0);
      csel = 1'b1;
      waitc(6);
      elapsed = 14;
      check({tag, " R10 busy poll"}, {30'd0, sdout_en, sdout}, 32'd2);
      while (sdout !== 1'b1 && elapsed < PC + 100) begin
         waitc(1);
         elapsed++;
      end
      check({tag, " R10 cycle length in window"},
            {31'd0, (elapsed >= PC && elapsed <= PC + 12)}, 32'd1);
      csel = 1'b0;
      waitc(10);
   endtask

   task automatic expect_idle(input string tag);
      csel = 1'b1;
      waitc(8);
      check({tag, " no programming cycle"}, {31'd0, sdout_en}, 32'd0);
      csel = 1'b0;
      waitc(6);
   endtask

   task automatic do_write(input int a, input logic [15:0] d);
      begin_cmd(2'b01);
      shift_out(32'(a), awid());
      shift_out({16'd0, d}, wide_mode ? 16 : 8);
   endtask

   task automatic read_seq(input int start, input int count, input string tag, input int lead = 0);
      logic r, e;
      logic [15:0] word, exp;
      int ba;
      begin_cmd(2'b10, lead);
      for (int i = awid() - 1; i >= 0; i--) sbit(start[i], r, e);
      check("R4 dummy zero before data", {30'd0, e, r}, 32'd2);
      for (int k = 0; k < count; k++) begin
         word = '0;
         for (int b = 0; b < (wide_mode ? 16 : 8); b++) begin
            sbit(1'b0, r, e);
            word = {word[14:0], r};
         end
         if (wide_mode) begin
            exp = model[(start + k) % NW];
         end else begin
            ba  = (start + k) % (2 * NW);
            exp = ba[0] ? {8'd0, model[ba >> 1][15:8]} : {8'd0, model[ba >> 1][7:0]};
         end
         check(tag, {16'd0, word}, {16'd0, exp});
      end
      end_cmd();
      check("R13 read output released", {31'd0, sdout_en}, 32'd0);
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge sys_clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         report();
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < NW; a++) model[a] = 16'hFFFF;
      waitc(5);
      check("R1 output disabled in reset", {31'd0, sdout_en}, 32'd0);
      rst_n = 1'b1;
      waitc(5);
      expect_idle("R1");

      // R1 erased array, R2 leading zeros ignored, R5 wrap
      read_seq(0, NW + 1, "R1 erased after reset", 2);

      // R9: latch clear after reset
      do_write(3, 16'h1234);
      end_cmd();
      expect_idle("R9 write with latch clear");
      read_seq(3, 1, "R9 word unchanged");

      ext_cmd(2'b11);
      end_cmd();

      // R6: fill the whole array
      for (int a = 0; a < NW; a++) begin
         model[a] = 16'((a * 4951) ^ 16'hA5C3);
         do_write(a, model[a]);
         expect_prog("R6");
      end
      read_seq(0, NW + 1, "R6 written pattern");
      read_seq(13, 5, "R5 sequential wrap");

      // R11: frame during programming ignored
      do_write(1, 16'hBEEF);
      csel = 1'b0;
      waitc(8);
      csel = 1'b1;
      waitc(4);
      begin
         logic r, e;
         sbit(1'b1, r, e);
      end
      shift_out(32'd3, 2);
      shift_out(32'd2, AW);
      check("R11 still busy during ignored frame", {30'd0, sdout_en, sdout}, 32'd2);
      csel = 1'b0;
      waitc(PC + 20);
      model[1] = 16'hBEEF;
      read_seq(1, 2, "R11 erase while busy ignored");

      // R7: erase word
      begin_cmd(2'b11);
      shift_out(32'd7, AW);
      expect_prog("R7");
      model[7] = 16'hFFFF;
      read_seq(6, 3, "R7 erased word");

      // R12: truncated write
      begin_cmd(2'b01);
      shift_out(32'd9, AW);
      shift_out(32'hAB, 8);
      end_cmd();
      expect_idle("R12");
      read_seq(9, 1, "R12 truncated write no effect");

      // R14: bits after a complete command
      ext_cmd(2'b11);
      begin
         logic r, e;
         sbit(1'b1, r, e);
      end
      shift_out(32'd3, 2);
      shift_out(32'd9, AW);
      end_cmd();
      expect_idle("R14");
      read_seq(9, 1, "R14 trailing bits ignored");

      // R3: byte mode
      wide_mode = 1'b0;
      waitc(4);
      do_write(11, 16'h005A);
      expect_prog("R3");
      model[5][15:8] = 8'h5A;
      begin_cmd(2'b11);
      shift_out(32'd10, AW + 1);
      expect_prog("R7 byte");
      model[5][7:0] = 8'hFF;
      read_seq(9, 4, "R3 byte read");
      read_seq(2 * NW - 2, 4, "R5 byte wrap");
      wide_mode = 1'b1;
      waitc(4);
      read_seq(5, 1, "R3 halves in word");

      // R8: erase all, write all
      ext_cmd(2'b10);
      expect_prog("R8");
      for (int a = 0; a < NW; a++) model[a] = 16'hFFFF;
      read_seq(0, NW, "R8 erase all");
      ext_cmd(2'b01);
      shift_out(32'hC3A5, 16);
      expect_prog("R8");
      for (int a = 0; a < NW; a++) model[a] = 16'hC3A5;
      read_seq(4, 3, "R8 write all word");
      wide_mode = 1'b0;
      waitc(4);
      ext_cmd(2'b01);
      shift_out(32'h7E, 8);
      expect_prog("R8");
      for (int a = 0; a < NW; a++) model[a] = 16'h7E7E;
      wide_mode = 1'b1;
      waitc(4);
      read_seq(0, NW, "R8 write all byte");

      // R9: disable latch again
      ext_cmd(2'b00);
      end_cmd();
      begin_cmd(2'b11);
      shift_out(32'd0, AW);
      end_cmd();
      expect_idle("R9 erase with latch clear");
      ext_cmd(2'b10);
      end_cmd();
      expect_idle("R9 erase all with latch clear");
      read_seq(0, 2, "R9 read with latch clear");

      done = 1'b1;
      report();
      $finish;
   end

endmodule